// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This block is one execution stage of a small 32-bit RISC core. It handles two immediate bit-field operations. It takes the instruction word, the value of the source register and the current value of the destination register, all sampled together under `in_valid`. One clock later it returns the new destination value, a write-enable, a flag that says the word was one of its two operations, and the two register indices it decoded.

The extract operation picks a field of a given width, starting at a given bit, out of the source value. It returns that field right-aligned and sets every higher bit to zero. The insert operation takes the low bits of the source value and places them in a window of the destination value. Every bit outside the window keeps its old value.

The two operations share one 5-bit immediate but read it differently. Extract reads it as the field width. Insert reads it as the index of the top bit of the window. Both use a second 5-bit immediate as the position of the field's lowest bit. A parameter chooses how the contiguous bit mask is built: with shifters or with per-bit comparators.

Top module: `bitfield_unit`

## Requirements
- R1: A word is recognised when `(word & 0xFC00C000)` equals `0x64004000` or `0x64008000`. Bits 31:26 must be 011001. Bits 15:14 then pick the operation: 01 is extract and 10 is insert. A recognised word raises `out_hit` and `out_wen`.
- R2: Any other word, including those with bits 15:14 equal to 00 or 11, gives `out_hit`=0, `out_wen`=0 and `out_result`=0.
- R3: For extract, the width is read from bits 10:6 and the start position from bits 4:0. The result is `(src >> start)` with only its low `width` bits kept. Every bit from index `width` upward is zero.
- R4: An extract whose width field is 0 gives a result of 0.
- R5: For insert, bits 10:6 give the top index `t` and bits 4:0 give the low index `s`. Result bits `s..t` take source bits `0..t-s`. Every other result bit equals the destination input.
- R6: An insert with `t < s` returns the destination input unchanged, with `out_wen`=1.
- R7: `out_rd` carries instruction bits 25:21 and `out_rs` carries bits 20:16. Both are registered with the result.
- R8: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low. The data outputs belong to that same cycle.
- R9: A synchronous active-high `rst` clears `out_valid` at the next clock edge, whatever `in_valid` is.
- R10: Instruction bits 13:11 and bit 5 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| in_instr | input | 32 | Instruction word |
| in_src | input | 32 | Source register value |
| in_dst | input | 32 | Current destination register value |
| out_valid | output | 1 | Registered outputs are valid |
| out_result | output | 32 | New destination value |
| out_wen | output | 1 | Destination write-enable |
| out_hit | output | 1 | Word was an extract or an insert |
| out_rd | output | 5 | Decoded destination index |
| out_rs | output | 5 | Decoded source index |

## Verification
The clocked assertions assume that `in_valid` and the operand buses hold known values at each rising edge. They also assume that `rst` is applied for at least one edge before any result is used. The bench drives every input on the falling edge and keeps `in_valid` low while reset is held at the start. Random words are drawn from four groups: legal extracts, legal inserts, near-miss encodings and arbitrary words. Inserts with a top index below the low index are deliberately included. The assertions do not need the width plus start to stay within 32, so the random extracts also exceed it.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;

   localparam int unsigned INSTR_W  = 32;
   localparam int unsigned REG_IDX_W = 5;
   localparam int unsigned IMM_W    = 5;

   localparam logic [INSTR_W-1:0] MATCH_MASK  = 32'hFC00_C000;
   localparam logic [INSTR_W-1:0] PAT_EXTRACT = 32'h6400_4000;
   localparam logic [INSTR_W-1:0] PAT_INSERT  = 32'h6400_8000;

   localparam int unsigned RD_LSB  = 21;
   localparam int unsigned RS_LSB  = 16;
   localparam int unsigned HI_LSB  = 6;
   localparam int unsigned LO_LSB  = 0;

   typedef enum logic [1:0] {
      BF_NONE    = 2'd0,
      BF_EXTRACT = 2'd1,
      BF_INSERT  = 2'd2
   } bf_op_e;

   typedef struct packed {
      bf_op_e                op;
      logic [REG_IDX_W-1:0]  rd;
      logic [REG_IDX_W-1:0]  rs;
      logic [IMM_W-1:0]      hi_imm;
      logic [IMM_W-1:0]      lo_imm;
   } bf_decoded_t;

endpackage

// File: rtl/bitfield_decode.sv
module bitfield_decode
   import bitfield_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output bf_decoded_t        dec
);

   logic [INSTR_W-1:0] masked;
   logic               unused_fields;

   assign masked        = instr & MATCH_MASK;
   assign unused_fields = ^{instr[13:11], instr[5]};

   always_comb begin
      if (masked == PAT_EXTRACT)
         dec.op = BF_EXTRACT;
      else if (masked == PAT_INSERT)
         dec.op = BF_INSERT;
      else
         dec.op = BF_NONE;
      dec.rd     = instr[RD_LSB +: REG_IDX_W];
      dec.rs     = instr[RS_LSB +: REG_IDX_W];
      dec.hi_imm = instr[HI_LSB +: IMM_W];
      dec.lo_imm = instr[LO_LSB +: IMM_W];
   end

endmodule

// File: rtl/bitfield_mask_gen.sv
module bitfield_mask_gen #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MASK_STYLE = 0,
   localparam int unsigned IDX_W     = $clog2(DATA_W)
) (
   input  logic              en,
   input  logic [IDX_W-1:0]  lo,
   input  logic [IDX_W-1:0]  hi,
   output logic [DATA_W-1:0] mask
);

   logic span_ok;
   assign span_ok = en && (hi >= lo);

   generate
      if (MASK_STYLE == 0) begin : g_shift
         logic [DATA_W-1:0] ones;
         logic [DATA_W-1:0] lower;
         logic [DATA_W-1:0] upper;
         logic [IDX_W:0]    rsh;
         assign ones  = '1;
         assign rsh   = (IDX_W+1)'(DATA_W - 1) - {1'b0, hi};
         assign lower = ones << lo;
         assign upper = ones >> rsh;
         assign mask  = span_ok ? (lower & upper) : '0;
      end else begin : g_compare
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            localparam logic [IDX_W-1:0] POS = IDX_W'(i);
            assign mask[i] = span_ok && (POS >= lo) && (POS <= hi);
         end
      end
   endgenerate

   always_comb begin
      if (span_ok) begin
         assert_mask_span_R5: assert ($countones(mask) == int'(hi) - int'(lo) + 1)
            else $error("mask span size wrong");
      end else begin
         assert_mask_empty_R6: assert (mask == '0)
            else $error("mask not empty");
      end
   end

endmodule

// File: rtl/bitfield_extract.sv
module bitfield_extract #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MASK_STYLE = 0,
   localparam int unsigned IDX_W     = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [IDX_W-1:0]  start,
   input  logic [IDX_W-1:0]  width,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] shifted;
   logic [IDX_W-1:0]  top;
   logic              nonzero;

   assign nonzero = (width != '0);
   assign top     = width - IDX_W'(1);
   assign shifted = src >> start;

   bitfield_mask_gen #(
      .DATA_W     (DATA_W),
      .MASK_STYLE (MASK_STYLE)
   ) u_mask (
      .en   (nonzero),
      .lo   ('0),
      .hi   (top),
      .mask (keep)
   );

   assign result = shifted & keep;

endmodule

// File: rtl/bitfield_insert.sv
module bitfield_insert #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MASK_STYLE = 0,
   localparam int unsigned IDX_W     = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   input  logic [IDX_W-1:0]  lo,
   input  logic [IDX_W-1:0]  hi,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] window;
   logic [DATA_W-1:0] placed;

   bitfield_mask_gen #(
      .DATA_W     (DATA_W),
      .MASK_STYLE (MASK_STYLE)
   ) u_mask (
      .en   (1'b1),
      .lo   (lo),
      .hi   (hi),
      .mask (window)
   );

   assign placed = src << lo;
   assign result = (dst & ~window) | (placed & window);

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
   import bitfield_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MASK_STYLE = 0,
   localparam int unsigned IDX_W     = $clog2(DATA_W)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [INSTR_W-1:0]   in_instr,
   input  logic [DATA_W-1:0]    in_src,
   input  logic [DATA_W-1:0]    in_dst,
   output logic                 out_valid,
   output logic [DATA_W-1:0]    out_result,
   output logic                 out_wen,
   output logic                 out_hit,
   output logic [REG_IDX_W-1:0] out_rd,
   output logic [REG_IDX_W-1:0] out_rs
);

   initial begin
      assert_cfg_width: assert (DATA_W == 32 && IDX_W == IMM_W)
         else $error("DATA_W must be 32 to match the 5-bit immediates");
      assert_cfg_style: assert (MASK_STYLE <= 1)
         else $error("MASK_STYLE must be 0 or 1");
   end

   bf_decoded_t       dec;
   logic [DATA_W-1:0] ext_res;
   logic [DATA_W-1:0] ins_res;
   logic [DATA_W-1:0] nxt_result;
   logic              nxt_hit;

   bitfield_decode u_dec (
      .instr (in_instr),
      .dec   (dec)
   );

   bitfield_extract #(
      .DATA_W     (DATA_W),
      .MASK_STYLE (MASK_STYLE)
   ) u_ext (
      .src    (in_src),
      .start  (dec.lo_imm),
      .width  (dec.hi_imm),
      .result (ext_res)
   );

   bitfield_insert #(
      .DATA_W     (DATA_W),
      .MASK_STYLE (MASK_STYLE)
   ) u_ins (
      .src    (in_src),
      .dst    (in_dst),
      .lo     (dec.lo_imm),
      .hi     (dec.hi_imm),
      .result (ins_res)
   );

   always_comb begin
      unique case (dec.op)
         BF_EXTRACT: begin nxt_result = ext_res; nxt_hit = 1'b1; end
         BF_INSERT:  begin nxt_result = ins_res; nxt_hit = 1'b1; end
         default:    begin nxt_result = '0;      nxt_hit = 1'b0; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_wen    <= 1'b0;
         out_hit    <= 1'b0;
         out_rd     <= '0;
         out_rs     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= nxt_result;
            out_wen    <= nxt_hit;
            out_hit    <= nxt_hit;
            out_rd     <= dec.rd;
            out_rs     <= dec.rs;
         end
      end
   end

   function automatic logic [DATA_W-1:0] span_bits(input int lo, input int hi);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int k = 0; k < DATA_W; k++)
         if (k >= lo && k <= hi) m[k] = 1'b1;
      return m;
   endfunction

   logic is_ext_in;
   logic is_ins_in;
   assign is_ext_in = ((in_instr & MATCH_MASK) == PAT_EXTRACT);
   assign is_ins_in = ((in_instr & MATCH_MASK) == PAT_INSERT);

   assert_valid_next_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid) else $error("out_valid missing");

   assert_idle_next_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid) else $error("spurious out_valid");

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> !out_valid) else $error("reset did not clear out_valid");

   assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_hit) |-> (!out_wen && out_result == '0))
      else $error("unrecognised word produced output");

   assert_hit_writes_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (is_ext_in || is_ins_in)) |=> (out_hit && out_wen))
      else $error("recognised word not flagged");

   assert_extract_top_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_ext_in) |=> ((out_result >> $past(in_instr[10:6])) == '0))
      else $error("extract left bits above field");

   assert_insert_keep_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_ins_in) |=>
         (((out_result ^ $past(in_dst)) &
           ~span_bits(int'($past(in_instr[4:0])), int'($past(in_instr[10:6])))) == '0))
      else $error("insert disturbed bits outside window");

endmodule

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] in_instr, in_src, in_dst;
   logic        out_valid, out_wen, out_hit;
   logic [31:0] out_result;
   logic [4:0]  out_rd, out_rs;

   always #10 clk = ~clk;

   bitfield_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
      .in_src(in_src), .in_dst(in_dst), .out_valid(out_valid),
      .out_result(out_result), .out_wen(out_wen), .out_hit(out_hit),
      .out_rd(out_rd), .out_rs(out_rs)
   );

   int checks = 0;
   int fails  = 0;

   logic        have_exp = 1'b0;
   logic        e_valid;
   logic [31:0] e_result;
   logic        e_wen, e_hit;
   logic [4:0]  e_rd, e_rs;
   string       e_tag;

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // reference: bit loops on integers, written from the requirements
   task automatic model(input logic [31:0] ins, input logic [31:0] src,
                        input logic [31:0] dst, output logic [31:0] res,
                        output logic hit);
      int w, s, t;
      logic is_ext, is_ins;
      is_ext = (ins[31:26] == 6'b011001) && (ins[15:14] == 2'b01);
      is_ins = (ins[31:26] == 6'b011001) && (ins[15:14] == 2'b10);
      w = int'(ins[10:6]);
      t = w;
      s = int'(ins[4:0]);
      res = 32'h0;
      hit = is_ext || is_ins;
      if (is_ext) begin
         for (int i = 0; i < w; i++)
            if (s + i < 32) res[i] = src[s + i];
      end else if (is_ins) begin
         res = dst;
         if (t >= s)
            for (int i = s; i <= t; i++) res[i] = src[i - s];
      end
   endtask

   task automatic compare();
      if (!have_exp) return;
      chk(out_valid === e_valid, e_tag, "out_valid", {31'b0, out_valid}, {31'b0, e_valid});
      if (e_valid) begin
         chk(out_result === e_result, e_tag, "out_result", out_result, e_result);
         chk(out_hit === e_hit, e_tag, "out_hit", {31'b0, out_hit}, {31'b0, e_hit});
         chk(out_wen === e_wen, e_tag, "out_wen", {31'b0, out_wen}, {31'b0, e_wen});
         chk(out_rd === e_rd, e_tag, "out_rd R7", {27'b0, out_rd}, {27'b0, e_rd});
         chk(out_rs === e_rs, e_tag, "out_rs R7", {27'b0, out_rs}, {27'b0, e_rs});
      end
   endtask

   task automatic drive(input logic v, input logic [31:0] ins, input logic [31:0] src,
                        input logic [31:0] dst, input string tag);
      logic [31:0] r;
      logic h;
      @(negedge clk);
      compare();
      rst = 1'b0;
      in_valid = v; in_instr = ins; in_src = src; in_dst = dst;
      model(ins, src, dst, r, h);
      e_valid = v; e_result = r; e_hit = h; e_wen = h;
      e_rd = ins[25:21]; e_rs = ins[20:16]; e_tag = tag;
      have_exp = 1'b1;
   endtask

   task automatic reset_cycle(input logic v, input string tag);
      @(negedge clk);
      compare();
      rst = 1'b1; in_valid = v;
      e_valid = 1'b0; e_tag = tag; have_exp = 1'b1;
   endtask

   function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] rd,
                                      input logic [4:0] rs, input logic [4:0] hi,
                                      input logic [4:0] lo);
      return {6'b011001, rd, rs, op, 3'b000, hi, 1'b0, lo};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_src = '0; in_dst = '0;
      reset_cycle(1'b0, "R9");
      reset_cycle(1'b0, "R9");
      reset_cycle(1'b0, "R9");
      // R3 extract cases
      drive(1, mk(2'b01, 5'd3, 5'd4, 5'd8, 5'd4), 32'hDEADBEEF, 32'h0, "R3");
      drive(1, mk(2'b01, 5'd1, 5'd2, 5'd31, 5'd1), 32'hFFFFFFFF, 32'h0, "R3");
      drive(1, mk(2'b01, 5'd1, 5'd2, 5'd1, 5'd31), 32'h80000000, 32'h0, "R3");
      drive(1, mk(2'b01, 5'd1, 5'd2, 5'd20, 5'd20), 32'hF0F0F0F0, 32'h0, "R3");
      // R4 zero width
      drive(1, mk(2'b01, 5'd7, 5'd8, 5'd0, 5'd9), 32'hFFFFFFFF, 32'hFFFFFFFF, "R4");
      // R5 insert cases
      drive(1, mk(2'b10, 5'd5, 5'd6, 5'd15, 5'd8), 32'h000000AB, 32'h12345678, "R5");
      drive(1, mk(2'b10, 5'd5, 5'd6, 5'd31, 5'd0), 32'hCAFEF00D, 32'h11111111, "R5");
      drive(1, mk(2'b10, 5'd5, 5'd6, 5'd31, 5'd31), 32'h00000001, 32'h00000000, "R5");
      drive(1, mk(2'b10, 5'd5, 5'd6, 5'd4, 5'd4), 32'hFFFFFFFE, 32'hFFFFFFFF, "R5");
      // R6 reversed window
      drive(1, mk(2'b10, 5'd9, 5'd10, 5'd3, 5'd10), 32'hFFFFFFFF, 32'hA5A5A5A5, "R6");
      // R1 / R2 recognition
      drive(1, 32'h64004000, 32'h12345678, 32'h9ABCDEF0, "R1");
      drive(1, 32'h64008000, 32'h12345678, 32'h9ABCDEF0, "R1");
      drive(1, 32'h64000000 | 32'h000002C4, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2");
      drive(1, 32'h6400C000 | 32'h000002C4, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2");
      drive(1, 32'h74004000 | 32'h000002C4, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2");
      drive(1, 32'h60004000 | 32'h000002C4, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2");
      // R7 indices
      drive(1, mk(2'b01, 5'd31, 5'd10, 5'd4, 5'd0), 32'h0000000F, 32'h0, "R7");
      drive(1, mk(2'b10, 5'd0, 5'd31, 5'd4, 5'd0), 32'h0000000F, 32'h0, "R7");
      // R10 don't-care bits set: same expected as clean word
      drive(1, mk(2'b01, 5'd2, 5'd3, 5'd8, 5'd4) | 32'h00003820, 32'hDEADBEEF, 32'h0, "R10");
      drive(1, mk(2'b10, 5'd2, 5'd3, 5'd15, 5'd8) | 32'h00003820, 32'h000000AB, 32'h12345678, "R10");
      // R8 gaps and back-to-back
      drive(0, mk(2'b01, 5'd2, 5'd3, 5'd8, 5'd4), 32'hDEADBEEF, 32'h0, "R8");
      drive(1, mk(2'b01, 5'd2, 5'd3, 5'd8, 5'd0), 32'h000000C3, 32'h0, "R8");
      drive(0, 32'h0, 32'h0, 32'h0, "R8");
      drive(0, 32'h0, 32'h0, 32'h0, "R8");
      // R9 mid-run reset with in_valid high
      reset_cycle(1'b1, "R9");
      drive(1, mk(2'b10, 5'd1, 5'd1, 5'd7, 5'd0), 32'h000000FF, 32'hFFFF0000, "R9");
      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] ins;
         int kind;
         kind = int'($urandom_range(0, 3));
         ins = $urandom;
         if (kind == 0)
            ins = (ins & ~32'hFC00C000) | 32'h64004000;
         else if (kind == 1)
            ins = (ins & ~32'hFC00C000) | 32'h64008000;
         else if (kind == 2)
            ins = (ins & ~32'hFC00C000) | 32'h64000000 | ({$urandom_range(0,1), 1'b0} == 2'b10 ? 32'h0000C000 : 32'h0);
         drive(($urandom_range(0, 3) != 0), ins, $urandom, $urandom,
               kind == 0 ? "R3" : kind == 1 ? "R5" : "R2");
      end
      drive(0, 32'h0, 32'h0, 32'h0, "R8");
      @(negedge clk);
      compare();
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule